// File: doc/BRIEF.md
# Fault-Record Stream Flip-Flop

This block is the sequential element of a fault simulator in which each circuit line carries a stream of tagged records rather than a single bit. A stream opens with a begin record that carries the line's fault-free value. Zero or more fault records follow, each naming a fault by its identifier and carrying the value that fault forces on the line. An end record closes the stream. Records cross the D and Q sides through valid/ready handshakes clocked by a fast stream clock `clk`. The circuit's own clock edge arrives as a one-cycle strobe `tick` in that same clock domain, so the circuit's clock period stays unchanged while whole streams move between its edges.

Between two ticks the element captures the stream arriving on D into one half of a two-bank store. During the same interval it replays, from the other half, the stream captured before the previous tick. On each tick the two halves swap roles. Fault effects therefore advance by exactly one circuit clock per tick. The first tick after reset has nothing to hand on, so it emits a stream holding only the two markers. This lets gates in feedback loops that wait on Q make progress. Two sticky flags report a capture buffer that overflowed and a tick that arrived before the D stream was closed.

Top module: `ffq_dff`

## Requirements
- R1: Synchronous active-high reset clears `q_valid`, `err_overflow` and `err_incomplete`, and leaves `d_ready` high in the first cycle after reset.
- R2: A record is a signed `TAG_W`-bit tag plus a 2-bit value. Tag 0 is the begin marker, tag -1 (all ones) is the end marker, and a positive tag is a fault identifier. Value code 2'b00 means unknown, 2'b01 means logic 0 and 2'b10 means logic 1. The value of the begin record is the good value.
- R3: Up to `DEPTH` fault records are kept per captured stream. Any later fault record is accepted but dropped, and it sets `err_overflow`, which stays set until reset.
- R4: In the cycle after a tick, Q presents the begin record carrying the captured good value. The captured fault records follow in arrival order, then an end record carrying the good value.
- R5: A D stream accepted while the previous stream is still replaying on Q is kept intact. The stream replayed after a tick is the one captured since the tick before it.
- R6: If the first tick after reset finds no begin record captured, Q emits only a begin and an end record, both with the unknown value, and `err_incomplete` stays clear.
- R7: In any other case where a tick finds the captured stream not closed by an end record, `err_incomplete` is set and stays set until reset. The partial stream is replayed with an end record added, and with the unknown good value if no begin record arrived.
- R8: `d_ready` is low during a tick cycle and from the accepted end record until the next tick.
- R9: Records that arrive before a begin record in a cycle are accepted and discarded.
- R10: While `q_valid` is high and `q_ready` is low, Q keeps the same record until a handshake or a tick.
- R11: A reset during operation re-arms the start-up case, so the next tick again behaves as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe marking a circuit clock edge |
| d_valid | input | 1 | D record valid |
| d_ready | output | 1 | D record accepted when high together with d_valid |
| d_tag | input | TAG_W | D record tag |
| d_val | input | 2 | D record value code |
| q_valid | output | 1 | Q record valid |
| q_ready | input | 1 | Downstream accepts the Q record |
| q_tag | output | TAG_W | Q record tag |
| q_val | output | 2 | Q record value code |
| err_overflow | output | 1 | Sticky capture overflow flag |
| err_incomplete | output | 1 | Sticky flag for a tick that arrived before the D stream was closed |

## Verification
The sharpest collision is a tick that lands in the same cycle that D presents the end marker of its stream. The bench provokes it by raising `tick` while that end record is offered. It expects `d_ready` to be low in that cycle and `err_incomplete` to become set. It also expects the stream already captured to be replayed with an end record added. The held end marker must then be swallowed as stray input of the new cycle, and the next complete stream must replay cleanly. A second overlap occurs on every ordinary tick: capture into one bank runs while the other bank replays. A scoreboard built from the requirements checks both streams record by record.

// File: rtl/ffq_pkg.sv
package ffq_pkg;
  localparam int VAL_W = 2;

  localparam logic [VAL_W-1:0] V_UNK  = 2'b00;
  localparam logic [VAL_W-1:0] V_ZERO = 2'b01;
  localparam logic [VAL_W-1:0] V_ONE  = 2'b10;

  typedef enum logic [1:0] {
    C_WAIT   = 2'd0,
    C_FAULTS = 2'd1,
    C_DONE   = 2'd2
  } cap_st_e;

  typedef enum logic [1:0] {
    R_OFF   = 2'd0,
    R_FAULT = 2'd1,
    R_END   = 2'd2
  } rep_st_e;
endpackage

// File: rtl/ffq_capture.sv
module ffq_capture
  import ffq_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int DW = TAG_W + VAL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             d_valid,
  output logic             d_ready,
  input  logic [TAG_W-1:0] d_tag,
  input  logic [VAL_W-1:0] d_val,
  output logic             wr_en,
  output logic [IW-1:0]    wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic [CW-1:0]    cap_cnt,
  output logic [VAL_W-1:0] cap_good,
  output logic             err_ovf,
  output logic             err_inc
);
  cap_st_e st;
  logic    armed;
  logic    acc, is_begin, is_end, is_fault, full;

  assign is_begin = (d_tag == '0);
  assign is_end   = (d_tag == '1);
  assign is_fault = !d_tag[TAG_W-1] && (d_tag != '0);
  assign full     = (cap_cnt == CW'(DEPTH));
  assign d_ready  = !tick && (st != C_DONE);
  assign acc      = d_valid && d_ready;

  assign wr_en   = acc && (st == C_FAULTS) && is_fault && !full;
  assign wr_idx  = cap_cnt[IW-1:0];
  assign wr_data = {d_tag, d_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= C_WAIT;
      cap_cnt  <= '0;
      cap_good <= V_UNK;
      armed    <= 1'b1;
      err_ovf  <= 1'b0;
      err_inc  <= 1'b0;
    end else if (tick) begin
      // only an untouched capture on the start-up tick is exempt
      if ((st != C_DONE) && !((st == C_WAIT) && armed))
        err_inc <= 1'b1;
      st       <= C_WAIT;
      cap_cnt  <= '0;
      cap_good <= V_UNK;
      armed    <= 1'b0;
    end else if (acc) begin
      case (st)
        C_WAIT: begin
          if (is_begin) begin
            st       <= C_FAULTS;
            cap_good <= d_val;
          end
        end
        C_FAULTS: begin
          if (is_end)
            st <= C_DONE;
          else if (is_fault) begin
            if (full) err_ovf <= 1'b1;
            else      cap_cnt <= cap_cnt + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ffq_store.sv
module ffq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 10,
  localparam int AW   = $clog2(2 * DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2*DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ffq_replay.sv
module ffq_replay
  import ffq_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int DW = TAG_W + VAL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CW-1:0]    load_cnt,
  input  logic [VAL_W-1:0] load_good,
  input  logic [DW-1:0]    rd_data,
  output logic [IW-1:0]    rd_idx,
  output logic             q_valid,
  input  logic             q_ready,
  output logic [TAG_W-1:0] q_tag,
  output logic [VAL_W-1:0] q_val
);
  rep_st_e          st;
  logic [CW-1:0]    cnt, idx, idx_n;
  logic [VAL_W-1:0] good;
  logic             adv;

  assign adv = !q_valid || q_ready;

  always_comb begin
    if (tick)                          idx_n = '0;
    else if (adv && (st == R_FAULT))   idx_n = idx + CW'(1);
    else                               idx_n = idx;
  end

  assign rd_idx = idx_n[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= R_OFF;
      q_valid <= 1'b0;
      q_tag   <= '0;
      q_val   <= V_UNK;
      cnt     <= '0;
      idx     <= '0;
      good    <= V_UNK;
    end else begin
      idx <= idx_n;
      if (tick) begin
        q_valid <= 1'b1;
        q_tag   <= '0;
        q_val   <= load_good;
        good    <= load_good;
        cnt     <= load_cnt;
        st      <= (load_cnt == '0) ? R_END : R_FAULT;
      end else if (adv) begin
        case (st)
          R_FAULT: begin
            q_valid <= 1'b1;
            q_tag   <= rd_data[DW-1:VAL_W];
            q_val   <= rd_data[VAL_W-1:0];
            if ((idx + CW'(1)) == cnt) st <= R_END;
          end
          R_END: begin
            q_valid <= 1'b1;
            q_tag   <= '1;
            q_val   <= good;
            st      <= R_OFF;
          end
          default: q_valid <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ffq_dff.sv
module ffq_dff
  import ffq_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             d_valid,
  output logic             d_ready,
  input  logic [TAG_W-1:0] d_tag,
  input  logic [1:0]       d_val,
  output logic             q_valid,
  input  logic             q_ready,
  output logic [TAG_W-1:0] q_tag,
  output logic [1:0]       q_val,
  output logic             err_overflow,
  output logic             err_incomplete
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int DW = TAG_W + VAL_W;
  localparam int AW = IW + 1;

  logic             cap_bank, rd_bank;
  logic             wr_en;
  logic [IW-1:0]    wr_idx, rd_idx;
  logic [DW-1:0]    wr_data, rd_data;
  logic [CW-1:0]    cap_cnt;
  logic [VAL_W-1:0] cap_good;

  always_ff @(posedge clk) begin
    if (rst)       cap_bank <= 1'b0;
    else if (tick) cap_bank <= ~cap_bank;
  end

  // read bank follows the bank that becomes the replay half after this edge
  assign rd_bank = tick ? cap_bank : ~cap_bank;

  ffq_capture #(.TAG_W(TAG_W), .DEPTH(DEPTH)) i_capture (
    .clk(clk), .rst(rst), .tick(tick),
    .d_valid(d_valid), .d_ready(d_ready), .d_tag(d_tag), .d_val(d_val),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cap_cnt(cap_cnt), .cap_good(cap_good),
    .err_ovf(err_overflow), .err_inc(err_incomplete)
  );

  ffq_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk(clk),
    .we(wr_en), .waddr({cap_bank, wr_idx}), .wdata(wr_data),
    .raddr({rd_bank, rd_idx}), .rdata(rd_data)
  );

  ffq_replay #(.TAG_W(TAG_W), .DEPTH(DEPTH)) i_replay (
    .clk(clk), .rst(rst), .tick(tick),
    .load_cnt(cap_cnt), .load_good(cap_good),
    .rd_data(rd_data), .rd_idx(rd_idx),
    .q_valid(q_valid), .q_ready(q_ready), .q_tag(q_tag), .q_val(q_val)
  );
endmodule

// File: rtl/ffq_dff_chk.sv
module ffq_dff_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             d_ready,
  input logic             q_valid,
  input logic             q_ready,
  input logic [TAG_W-1:0] q_tag,
  input logic [1:0]       q_val,
  input logic             err_overflow,
  input logic             err_incomplete
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R1: assert (!q_valid && !err_overflow && !err_incomplete)
        else $error("outputs not cleared by reset");
    end
  end

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    err_overflow |=> err_overflow);

  assert_begin_after_tick_R4: assert property (@(posedge clk) disable iff (rst)
    tick |=> (q_valid && (q_tag == '0)));

  assert_inc_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_incomplete |=> err_incomplete);

  assert_no_ready_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    tick |-> !d_ready);

  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !q_ready && !tick) |=> (q_valid && $stable(q_tag) && $stable(q_val)));
endmodule

bind ffq_dff ffq_dff_chk #(.TAG_W(TAG_W)) i_ffq_dff_chk (
  .clk(clk), .rst(rst), .tick(tick), .d_ready(d_ready),
  .q_valid(q_valid), .q_ready(q_ready), .q_tag(q_tag), .q_val(q_val),
  .err_overflow(err_overflow), .err_incomplete(err_incomplete)
);

// File: tb/test_ffq_dff.sv
module test_ffq_dff;
  localparam int TAG_W = 8;
  localparam int DEPTH = 16;
  localparam logic [1:0] UNK = 2'b00, ZRO = 2'b01, ONE = 2'b10;
  localparam logic [TAG_W-1:0] T_BEG = '0, T_END = '1;

  typedef struct packed { logic [TAG_W-1:0] tag; logic [1:0] val; } rec_t;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic d_valid = 1'b0, d_ready, q_valid, q_ready = 1'b1;
  logic [TAG_W-1:0] d_tag = '0, q_tag;
  logic [1:0] d_val = UNK, q_val;
  logic err_overflow, err_incomplete;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ffq_dff #(.TAG_W(TAG_W), .DEPTH(DEPTH)) i_ffq_dff (
    .clk(clk), .rst(rst), .tick(tick),
    .d_valid(d_valid), .d_ready(d_ready), .d_tag(d_tag), .d_val(d_val),
    .q_valid(q_valid), .q_ready(q_ready), .q_tag(q_tag), .q_val(q_val),
    .err_overflow(err_overflow), .err_incomplete(err_incomplete)
  );

  // requirement model
  rec_t sb[$];
  rec_t m_faults[$];
  int   m_st = 0;
  bit   m_armed = 1;
  logic [1:0] m_good = UNK;
  bit   exp_ovf = 0, exp_inc = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_accept(logic [TAG_W-1:0] t, logic [1:0] v);
    if (m_st == 0) begin
      if (t == T_BEG) begin m_st = 1; m_good = v; end
    end else if (m_st == 1) begin
      if (t == T_END) m_st = 2;
      else if (!t[TAG_W-1] && t != '0) begin
        if (m_faults.size() == DEPTH) exp_ovf = 1;
        else m_faults.push_back('{tag: t, val: v});
      end
    end
  endfunction

  function automatic void model_tick();
    if (m_st != 2 && !(m_st == 0 && m_armed)) exp_inc = 1;
    sb.push_back('{tag: T_BEG, val: m_good});
    foreach (m_faults[i]) sb.push_back(m_faults[i]);
    sb.push_back('{tag: T_END, val: m_good});
    m_faults.delete();
    m_st = 0; m_good = UNK; m_armed = 0;
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && q_valid && q_ready) begin
        if (sb.size() == 0)
          check(0, "R4 unexpected Q record", int'({q_tag, q_val}), 0);
        else begin
          rec_t e;
          e = sb.pop_front();
          check({q_tag, q_val} == e, "R4/R5 Q record {tag,val}",
                int'({q_tag, q_val}), int'(e));
        end
      end
    end
  end

  task automatic send(logic [TAG_W-1:0] t, logic [1:0] v);
    bit acc = 0;
    d_valid = 1; d_tag = t; d_val = v;
    while (!acc) begin
      @(negedge clk);
      acc = d_ready;
      @(posedge clk); #1;
    end
    model_accept(t, v);
    d_valid = 0;
  endtask

  task automatic wait_empty();
    while (sb.size() != 0) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_tick();
    wait_empty();
    tick = 1;
    model_tick();
    @(negedge clk);
    check(d_ready == 0, "R8 d_ready in tick cycle", d_ready, 0);
    @(posedge clk); #1;
    tick = 0;
  endtask

  task automatic drain();
    wait_empty();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic check_flags(string req);
    @(negedge clk);
    check(err_overflow == exp_ovf, {req, " err_overflow"}, err_overflow, exp_ovf);
    check(err_incomplete == exp_inc, {req, " err_incomplete"}, err_incomplete, exp_inc);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(q_valid == 0, "R1 q_valid after reset", q_valid, 0);
    check(d_ready == 1, "R1 d_ready after reset", d_ready, 1);
    @(posedge clk); #1;
    check_flags("R1");

    // R6 start-up tick with nothing captured
    pulse_tick();
    drain();
    check_flags("R6");

    // R4/R5 normal stream, then next stream captured during replay
    send(T_BEG, ONE); send(8'd5, ZRO); send(8'd9, ONE); send(8'd3, ZRO); send(T_END, ONE);
    @(negedge clk);
    check(d_ready == 0, "R8 d_ready after end marker", d_ready, 0);
    @(posedge clk); #1;
    pulse_tick();
    send(T_BEG, ZRO); send(8'd7, ONE); send(8'd12, ONE); send(T_END, ZRO);
    pulse_tick();
    send(T_BEG, ONE); send(T_END, ONE);
    pulse_tick();
    // R9 stray records before begin
    send(8'd4, ONE); send(T_END, ZRO); send(T_BEG, ZRO); send(8'd2, ONE); send(T_END, ZRO);
    pulse_tick();
    drain();
    check_flags("R2/R9");

    // R10 stall on Q
    send(T_BEG, ONE); send(8'd20, ZRO); send(8'd21, ZRO); send(T_END, ONE);
    q_ready = 0;
    pulse_tick();
    begin
      logic [TAG_W-1:0] t0; logic [1:0] v0;
      @(negedge clk);
      t0 = q_tag; v0 = q_val;
      repeat (3) @(negedge clk);
      check(q_valid == 1, "R10 q_valid held", q_valid, 1);
      check({q_tag, q_val} == {t0, v0}, "R10 record held", int'({q_tag, q_val}), int'({t0, v0}));
      @(posedge clk); #1;
    end
    q_ready = 1;
    drain();

    // R3 overflow
    send(T_BEG, ZRO);
    for (int i = 1; i <= DEPTH; i++) send(TAG_W'(i), (i % 2) ? ONE : ZRO);
    check_flags("R3 at capacity");
    send(8'd17, ONE); send(8'd18, ONE);
    check_flags("R3 past capacity");
    send(T_END, ZRO);
    pulse_tick();
    drain();
    check_flags("R3 sticky");

    // R7 tick collides with the end marker
    send(T_BEG, ONE); send(8'd6, ZRO);
    wait_empty();
    d_valid = 1; d_tag = T_END; d_val = ONE;
    tick = 1;
    model_tick();
    @(negedge clk);
    check(d_ready == 0, "R8 end marker held on tick", d_ready, 0);
    @(posedge clk); #1;
    tick = 0;
    begin
      bit acc = 0;
      while (!acc) begin
        @(negedge clk); acc = d_ready;
        @(posedge clk); #1;
      end
    end
    model_accept(T_END, ONE);
    d_valid = 0;
    check_flags("R7 collision");
    drain();
    send(T_BEG, ZRO); send(8'd30, ONE); send(T_END, ZRO);
    pulse_tick();
    drain();

    // R11 reset re-arms start-up
    rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    m_faults.delete(); m_st = 0; m_good = UNK; m_armed = 1; exp_ovf = 0; exp_inc = 0;
    check_flags("R1/R11 after reset");
    pulse_tick();
    drain();
    check_flags("R11 start-up tick");
    pulse_tick();
    drain();
    check_flags("R7 empty tick");

    check(sb.size() == 0, "R4 scoreboard empty", sb.size(), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule